// File: doc/BRIEF.md
# Trip Flag and Interrupt Latch

This block records fault events for one PWM channel and turns them into a trip interrupt. It watches six fault sources: a one-shot trip, a cycle-by-cycle trip and four compare-event strobes. Each source has its own sticky flag in a 16-bit read-only status word. Software clears any flag by writing a one to the matching bit of a separate clear port.

Beside the flags, the block keeps the cycle-by-cycle condition that the PWM output stage acts on. This condition is separate from its flag. It drops only at the time-base counter-zero point, and only when the trip input has gone away. The flag, by contrast, drops only when software clears it.

The interrupt is a latched flag with a one-clock output pulse. While the flag is set, no further pulse is produced. If software acknowledges the interrupt while a one-shot or cycle-by-cycle flag is still latched, the interrupt re-arms and fires again.

Top module: `trip_latch`

## Requirements
- R1: After reset, every flag bit, `cbc_active` and `trip_int` are 0.
- R2: Status bits 15:7 always read 0.
- R3: The one-shot flag (bit 2) is set on the edge after `ost_trip` is 1. It holds until a cycle where `flag_clr[2]` is 1 and `ost_trip` is 0.
- R4: Compare events `dc_evt[0..3]` set status bits 3, 4, 5 and 6 respectively, and map to clear bits 3 to 6 in the same way. Each flag holds until cleared.
- R5: The cycle-by-cycle flag (bit 1) is set by `cbc_trip` and cleared only by `flag_clr[1]`. If `cbc_trip` is 1 in the clear cycle, the flag stays 1.
- R6: `cbc_active` is set on the edge after `cbc_trip` is 1. It falls only on an edge where `tb_zero` is 1 and `cbc_trip` is 0. Clearing the flag does not affect it.
- R7: When a source event and a clear of that same flag arrive in one cycle, the flag ends up set.
- R8: An enabled new event while the interrupt flag (bit 0) is clear sets bit 0. It also produces a one-clock pulse on `trip_int` in the next cycle.
- R9: While bit 0 stays set and is not being cleared, `trip_int` stays 0.
- R10: Clearing bit 0 while the enabled one-shot or cycle-by-cycle flag remains set produces a new pulse and sets bit 0 again.
- R11: A cycle that clears all seven flags with no event present produces no pulse on the next cycle.
- R12: `int_en` bit mapping is: bit 0 cycle-by-cycle, bit 1 one-shot, bits 2 to 5 compare events 0 to 3. A source whose enable bit is 0 still latches its flag but produces no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ost_trip | input | 1 | One-shot trip event |
| cbc_trip | input | 1 | Cycle-by-cycle trip level |
| dc_evt | input | 4 | Compare event strobes |
| tb_zero | input | 1 | Time-base counter-zero pulse |
| flag_clr | input | 7 | Write-one-to-clear strobes, one per flag bit 6:0 |
| int_en | input | 6 | Per-source interrupt enables |
| flags | output | 16 | Latched status word |
| cbc_active | output | 1 | Cycle-by-cycle trip condition for the output stage |
| trip_int | output | 1 | One-clock interrupt pulse |

## Verification
Two functions can land on the same edge: a flag clear from software and a new event on that same source. A second pair is an interrupt acknowledge and the re-arm it causes. The vectors drive `flag_clr` together with `cbc_trip` or `ost_trip` in one cycle and expect the flag to survive. They also expect a fresh pulse when bit 0 is acknowledged while the one-shot flag is latched, and none after a full clear with no event present. A further vector clears the cycle-by-cycle flag away from counter zero and checks that `cbc_active` holds until the next `tb_zero`.

// File: rtl/trip_latch.sv
module trip_latch #(
  parameter int NDC = 4,
  parameter int FW  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ost_trip,
  input  logic             cbc_trip,
  input  logic [NDC-1:0]   dc_evt,
  input  logic             tb_zero,
  input  logic [NDC+2:0]   flag_clr,
  input  logic [NDC+1:0]   int_en,
  output logic [FW-1:0]    flags,
  output logic             cbc_active,
  output logic             trip_int
);
  localparam int NSRC = NDC + 2;
  localparam int NF   = NSRC + 1;

  logic [NSRC-1:0] src_q, src_in, src_d;
  logic int_q, cbc_q, pulse_q;
  logic int_hold, rearm, fire;

  assign src_in   = {dc_evt, ost_trip, cbc_trip};
  assign src_d    = (src_q & ~flag_clr[NF-1:1]) | src_in;
  assign int_hold = int_q & ~flag_clr[0];
  assign rearm    = int_q & flag_clr[0] & (|(int_en[1:0] & src_d[1:0]));
  assign fire     = ~int_hold & ((|(int_en & src_in)) | rearm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      int_q   <= 1'b0;
      cbc_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      src_q   <= src_d;
      int_q   <= int_hold | fire;
      cbc_q   <= cbc_trip | (cbc_q & ~tb_zero);
      pulse_q <= fire;
    end
  end

  assign flags      = {{(FW-NF){1'b0}}, src_q, int_q};
  assign cbc_active = cbc_q;
  assign trip_int   = pulse_q;
endmodule

// File: rtl/trip_latch_chk.sv
module trip_latch_chk #(
  parameter int NDC = 4,
  parameter int FW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ost_trip,
  input logic           cbc_trip,
  input logic [NDC-1:0] dc_evt,
  input logic           tb_zero,
  input logic [NDC+2:0] flag_clr,
  input logic [NDC+1:0] int_en,
  input logic [FW-1:0]  flags,
  input logic           cbc_active,
  input logic           trip_int
);
  localparam int NF = NDC + 3;

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FW-1:NF] == '0);
  a_r3_ost_latches: assert property (@(posedge clk) disable iff (!rst_n)
    ost_trip |=> flags[2]);
  a_r5_cbc_flag_latches: assert property (@(posedge clk) disable iff (!rst_n)
    cbc_trip |=> flags[1]);
  a_r6_cbc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cbc_active && !tb_zero) |=> cbc_active);
  a_r6_cbc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cbc_trip |=> cbc_active);
  a_r8_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    trip_int |-> flags[0]);
  a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !flag_clr[0]) |=> !trip_int);
  a_r11_clear_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&flag_clr && !ost_trip && !cbc_trip && dc_evt == '0) |=> !trip_int);
endmodule

bind trip_latch trip_latch_chk u_chk (.*);

// File: tb/sim_trip_latch.sv
`timescale 1ns/1ps
module sim_trip_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ost_trip = 1'b0, cbc_trip = 1'b0, tb_zero = 1'b0;
  logic [3:0] dc_evt = '0;
  logic [6:0] flag_clr = '0;
  logic [5:0] int_en = '0;
  logic [15:0] flags;
  logic cbc_active, trip_int;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  trip_latch u0 (.clk(clk), .rst_n(rst_n), .ost_trip(ost_trip), .cbc_trip(cbc_trip),
    .dc_evt(dc_evt), .tb_zero(tb_zero), .flag_clr(flag_clr), .int_en(int_en),
    .flags(flags), .cbc_active(cbc_active), .trip_int(trip_int));

  // vector: req(4) ost cbc dc(4) tbz clr(7) en(6) | flags[6:0] act int
  localparam int NV = 15;
  localparam logic [32:0] VEC [NV] = '{
    {4'd8,  1'b1,1'b0,4'b0000,1'b0,7'h00,6'h3f, 7'b0000101,1'b0,1'b1}, // R3 R8
    {4'd9,  1'b0,1'b0,4'b0000,1'b0,7'h00,6'h3f, 7'b0000101,1'b0,1'b0}, // R9
    {4'd4,  1'b0,1'b0,4'b0001,1'b0,7'h00,6'h3f, 7'b0001101,1'b0,1'b0}, // R4 R9
    {4'd10, 1'b0,1'b0,4'b0000,1'b0,7'h01,6'h3f, 7'b0001101,1'b0,1'b1}, // R10
    {4'd11, 1'b0,1'b0,4'b0000,1'b0,7'h7f,6'h3f, 7'b0000000,1'b0,1'b0}, // R11 R3 R4
    {4'd5,  1'b0,1'b1,4'b0000,1'b0,7'h00,6'h3f, 7'b0000011,1'b1,1'b1}, // R5 R6
    {4'd7,  1'b0,1'b1,4'b0000,1'b0,7'h02,6'h3f, 7'b0000011,1'b1,1'b0}, // R5 R7
    {4'd6,  1'b0,1'b0,4'b0000,1'b0,7'h02,6'h3f, 7'b0000001,1'b1,1'b0}, // R6
    {4'd6,  1'b0,1'b0,4'b0000,1'b1,7'h00,6'h3f, 7'b0000001,1'b0,1'b0}, // R6
    {4'd10, 1'b0,1'b0,4'b0000,1'b0,7'h01,6'h3f, 7'b0000000,1'b0,1'b0}, // R10
    {4'd12, 1'b1,1'b0,4'b1000,1'b0,7'h00,6'h00, 7'b1000100,1'b0,1'b0}, // R12 R4
    {4'd12, 1'b0,1'b0,4'b0000,1'b0,7'h00,6'h02, 7'b1000100,1'b0,1'b0}, // R12
    {4'd12, 1'b0,1'b1,4'b0000,1'b1,7'h00,6'h02, 7'b1000110,1'b1,1'b0}, // R12 R6
    {4'd6,  1'b0,1'b0,4'b0000,1'b1,7'h00,6'h3f, 7'b1000110,1'b0,1'b0}, // R6
    {4'd7,  1'b1,1'b0,4'b0000,1'b0,7'h7f,6'h3f, 7'b0000101,1'b0,1'b1}  // R7 R8
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reset_check();
    chk(1, {16'h0, flags}, 32'h0);        // R1
    chk(1, {31'h0, cbc_active}, 32'h0);   // R1
    chk(1, {31'h0, trip_int}, 32'h0);     // R1
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 reset_check();
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      @(negedge clk);
      ost_trip = v[28]; cbc_trip = v[27]; dc_evt = v[26:23]; tb_zero = v[22];
      flag_clr = v[21:15]; int_en = v[14:9];
      @(posedge clk); #1;
      chk(v[32:29], {25'h0, flags[6:0]}, {25'h0, v[8:2]});
      chk(v[32:29], {31'h0, cbc_active}, {31'h0, v[1]});
      chk(v[32:29], {31'h0, trip_int}, {31'h0, v[0]});
      chk(2, {23'h0, flags[15:7]}, 32'h0);  // R2
    end
    @(negedge clk);
    ost_trip = 0; cbc_trip = 1; dc_evt = 0; tb_zero = 0; flag_clr = 0; int_en = 6'h3f;
    @(negedge clk) cbc_trip = 0;
    @(negedge clk) rst_n = 1'b0;                 // R1 mid-run reset
    @(posedge clk); #1 reset_check();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule